// File: doc/BRIEF.md
# Slot-Timed Multi-Rail Power Sequencer

This block switches a bank of enable outputs (regulator enables, GPIO enables and a 32 kHz clock enable) in a programmed order. Three master timers each watch one trigger. The trigger can be hardware pin 0, hardware pin 1 or a software bit. Whenever a master's trigger changes level, the master runs a sequence of eight slot events. The events are spaced by a programmable period counted in `tick` cycles. A rising trigger starts a power-up sequence and a falling trigger starts a power-down sequence.

Each output (a "rail") is bound either to one master or to its own software enable bit. A bound rail turns on at its power-up slot. At its power-down slot it applies the master's clear policy, which has three choices: switch off, stay on in low-power mode, or leave the rail unchanged. A combined power-good output reports whether every monitored rail is good.

The block has no data stream, so every pin is a plain level-sensitive control or status signal with no valid/ready handshake. Configuration is held on static register inputs. It is meant to be changed only while the affected masters are idle.

Top module: `pwr_seq_top`

## Requirements
- R1: Master source field `m_src` (2 bits per master) selects its trigger: 0 = `hw_en0`, 1 = `hw_en1`, 2 = that master's `sw_trig` bit, 3 = none (trigger held low). Activity on a pin that is not selected starts no sequence.
- R2: A trigger change sampled at clock edge E0 starts a sequence. With period P = BASE_TICKS << `m_period` ticks (default BASE_TICKS = 40, so 40 to 5120 ticks), slot k (0..7) fires P·(k+1) ticks after E0. `m_busy` is high from E0 until slot 7. `m_done` pulses for one cycle with slot 7.
- R3: Rail source field `s_src` (2 bits per rail) selects master 0..2, or 3 = software. A master-bound rail goes on, with low-power indication cleared, at its `s_up` slot (3 bits) of a rising sequence. With `tick` held high, the output changes at edge E0 + P·(k+1) + 1.
- R4: Policy field `m_policy` (2 bits per master) value 1 (sleep) turns a bound rail off at its `s_dn` slot of a falling sequence.
- R5: Policy 2 (low power) leaves a bound rail on at its `s_dn` slot and raises its `s_lp`. `s_lp` is only ever high while `s_en` is high.
- R6: Policy 0 or 3 (none): a falling sequence leaves `s_en` and `s_lp` unchanged.
- R7: A software-sourced rail copies `s_sw_on` to `s_en` one clock later and holds `s_lp` low.
- R8: A trigger change while a sequence runs aborts it. A new sequence in the new direction starts from slot 0, slots of the aborted sequence that have not fired never fire, and `m_done` pulses only at the end of the new sequence.
- R9: `pg_ok` is high exactly when every rail with `pg_mon` set has `pg_in` high. It falls in the same cycle that a monitored input falls.
- R10: After reset all `s_en`, `s_lp`, `m_busy` and `m_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time base strobe (one per microsecond) |
| hw_en0 | input | 1 | Hardware trigger pin 0 |
| hw_en1 | input | 1 | Hardware trigger pin 1 |
| sw_trig | input | N_MASTER | Software trigger bit per master |
| m_src | input | 2*N_MASTER | Trigger select per master |
| m_period | input | 3*N_MASTER | Slot period code per master |
| m_policy | input | 2*N_MASTER | Clear policy per master |
| s_src | input | 2*N_SLAVE | Rail source select |
| s_up | input | 3*N_SLAVE | Power-up slot per rail |
| s_dn | input | 3*N_SLAVE | Power-down slot per rail |
| s_sw_on | input | N_SLAVE | Software enable per rail |
| pg_mon | input | N_SLAVE | Power-good monitor enable per rail |
| pg_in | input | N_SLAVE | Power-good input per rail |
| s_en | output | N_SLAVE | Rail enable |
| s_lp | output | N_SLAVE | Rail low-power indication |
| m_busy | output | N_MASTER | Master sequence in progress |
| m_done | output | N_MASTER | Master sequence finished pulse |
| pg_ok | output | 1 | Combined power-good |

## Verification
The bound checker watches properties that hold on every cycle. It checks that low-power indication never appears on a disabled rail, that software-sourced rails track their enable bit one cycle late, that a monitored bad rail forces `pg_ok` low, and that `m_busy` drops only together with a single-cycle `m_done`. Exact slot timing cannot be seen cycle by cycle, and the bench's scenarios are what show it. They cover every period code, every trigger choice, both directions and all three clear policies. Separate scenarios cover abort-and-restart and the rejection of unselected triggers.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SLOT_W  = 3;
  localparam int N_SLOTS = 1 << SLOT_W;
  localparam int PER_W   = 3;
  localparam int SRC_W   = 2;
  localparam int POL_W   = 2;

  typedef enum logic [SRC_W-1:0] {
    MSRC_EN0 = 2'd0,
    MSRC_EN1 = 2'd1,
    MSRC_SW  = 2'd2,
    MSRC_OFF = 2'd3
  } msrc_e;

  typedef enum logic [POL_W-1:0] {
    POL_KEEP   = 2'd0,
    POL_SLEEP  = 2'd1,
    POL_LOWPWR = 2'd2,
    POL_KEEP2  = 2'd3
  } pol_e;

  localparam logic [SRC_W-1:0] RAIL_SRC_SW = 2'd3;

  typedef struct packed {
    logic              fire;
    logic              up;
    logic [SLOT_W-1:0] slot;
  } slot_evt_t;
endpackage

// File: rtl/seq_master.sv
module seq_master
  import seq_pkg::*;
#(
  parameter int BASE_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en0,
  input  logic             en1,
  input  logic             sw,
  input  logic [SRC_W-1:0] src,
  input  logic [PER_W-1:0] per_code,
  output slot_evt_t        evt,
  output logic             busy,
  output logic             done
);
  localparam int MAX_TICKS = BASE_TICKS << ((1 << PER_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS);

  logic              trig, trig_q, dir_q;
  logic [CNT_W-1:0]  cnt, reload;
  logic [SLOT_W-1:0] idx;

  always_comb begin
    case (msrc_e'(src))
      MSRC_EN0: trig = en0;
      MSRC_EN1: trig = en1;
      MSRC_SW:  trig = sw;
      default:  trig = 1'b0;
    endcase
  end

  assign reload = CNT_W'((BASE_TICKS << per_code) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      dir_q  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      evt    <= '0;
    end else begin
      evt  <= '0;
      done <= 1'b0;
      if (trig != trig_q) begin
        // new edge: start (or restart) from slot 0
        trig_q <= trig;
        dir_q  <= trig;
        busy   <= 1'b1;
        cnt    <= reload;
        idx    <= '0;
      end else if (busy && tick) begin
        if (cnt == '0) begin
          evt.fire <= 1'b1;
          evt.up   <= dir_q;
          evt.slot <= idx;
          if (idx == SLOT_W'(N_SLOTS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            cnt <= reload;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_slave.sv
module seq_slave
  import seq_pkg::*;
#(
  parameter int N_MASTER = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  slot_evt_t [N_MASTER-1:0]    evts,
  input  logic [POL_W*N_MASTER-1:0]   policy,
  input  logic [SRC_W-1:0]            src,
  input  logic [SLOT_W-1:0]           up_slot,
  input  logic [SLOT_W-1:0]           dn_slot,
  input  logic                        sw_on,
  output logic                        en,
  output logic                        lp
);
  slot_evt_t        ev;
  logic [POL_W-1:0] pl;
  logic             is_sw;

  always_comb begin
    is_sw = (src == RAIL_SRC_SW) || (int'(src) >= N_MASTER);
    ev    = '0;
    pl    = '0;
    if (!is_sw) begin
      ev = evts[src];
      pl = policy[int'(src)*POL_W +: POL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      lp <= 1'b0;
    end else if (is_sw) begin
      en <= sw_on;
      lp <= 1'b0;
    end else if (ev.fire) begin
      if (ev.up && ev.slot == up_slot) begin
        en <= 1'b1;
        lp <= 1'b0;
      end else if (!ev.up && ev.slot == dn_slot) begin
        case (pol_e'(pl))
          POL_SLEEP: begin
            en <= 1'b0;
            lp <= 1'b0;
          end
          POL_LOWPWR: lp <= en;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/seq_pg_and.sv
module seq_pg_and #(
  parameter int N = 8
) (
  input  logic [N-1:0] mon,
  input  logic [N-1:0] good,
  output logic         ok
);
  assign ok = &(~mon | good);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import seq_pkg::*;
#(
  parameter int N_MASTER   = 3,
  parameter int N_SLAVE    = 8,
  parameter int BASE_TICKS = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      hw_en0,
  input  logic                      hw_en1,
  input  logic [N_MASTER-1:0]       sw_trig,
  input  logic [SRC_W*N_MASTER-1:0] m_src,
  input  logic [PER_W*N_MASTER-1:0] m_period,
  input  logic [POL_W*N_MASTER-1:0] m_policy,
  input  logic [SRC_W*N_SLAVE-1:0]  s_src,
  input  logic [SLOT_W*N_SLAVE-1:0] s_up,
  input  logic [SLOT_W*N_SLAVE-1:0] s_dn,
  input  logic [N_SLAVE-1:0]        s_sw_on,
  input  logic [N_SLAVE-1:0]        pg_mon,
  input  logic [N_SLAVE-1:0]        pg_in,
  output logic [N_SLAVE-1:0]        s_en,
  output logic [N_SLAVE-1:0]        s_lp,
  output logic [N_MASTER-1:0]       m_busy,
  output logic [N_MASTER-1:0]       m_done,
  output logic                      pg_ok
);
  slot_evt_t [N_MASTER-1:0] evts;

  for (genvar m = 0; m < N_MASTER; m++) begin : g_master
    seq_master #(.BASE_TICKS(BASE_TICKS)) u_master (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .en0      (hw_en0),
      .en1      (hw_en1),
      .sw       (sw_trig[m]),
      .src      (m_src[m*SRC_W +: SRC_W]),
      .per_code (m_period[m*PER_W +: PER_W]),
      .evt      (evts[m]),
      .busy     (m_busy[m]),
      .done     (m_done[m])
    );
  end

  for (genvar s = 0; s < N_SLAVE; s++) begin : g_rail
    seq_slave #(.N_MASTER(N_MASTER)) u_rail (
      .clk     (clk),
      .rst_n   (rst_n),
      .evts    (evts),
      .policy  (m_policy),
      .src     (s_src[s*SRC_W +: SRC_W]),
      .up_slot (s_up[s*SLOT_W +: SLOT_W]),
      .dn_slot (s_dn[s*SLOT_W +: SLOT_W]),
      .sw_on   (s_sw_on[s]),
      .en      (s_en[s]),
      .lp      (s_lp[s])
    );
  end

  seq_pg_and #(.N(N_SLAVE)) u_pg (
    .mon  (pg_mon),
    .good (pg_in),
    .ok   (pg_ok)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import seq_pkg::*;
#(
  parameter int N_MASTER = 3,
  parameter int N_SLAVE  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SRC_W*N_SLAVE-1:0] s_src,
  input logic [N_SLAVE-1:0]       s_sw_on,
  input logic [N_SLAVE-1:0]       s_en,
  input logic [N_SLAVE-1:0]       s_lp,
  input logic [N_SLAVE-1:0]       pg_mon,
  input logic [N_SLAVE-1:0]       pg_in,
  input logic [N_MASTER-1:0]      m_busy,
  input logic [N_MASTER-1:0]      m_done,
  input logic                     pg_ok
);
  for (genvar m = 0; m < N_MASTER; m++) begin : g_m
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(m_busy[m]) |-> m_done[m]);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_done[m] |=> !m_done[m]);
  end

  for (genvar s = 0; s < N_SLAVE; s++) begin : g_s
    // R5
    lp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_lp[s] |-> s_en[s]);
    // R7
    sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && s_src[s*SRC_W +: SRC_W] == RAIL_SRC_SW
       && $past(s_src[s*SRC_W +: SRC_W]) == RAIL_SRC_SW)
      |-> (s_en[s] == $past(s_sw_on[s]) && !s_lp[s]));
  end

  // R9
  pg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pg_mon & ~pg_in)) |-> !pg_ok);
endmodule

bind pwr_seq_top seq_chk #(.N_MASTER(N_MASTER), .N_SLAVE(N_SLAVE)) u_chk (.*);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int NS = 8;
  localparam int BT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic hw_en0 = 1'b0, hw_en1 = 1'b0;
  logic [NM-1:0]   sw_trig = '0;
  logic [2*NM-1:0] m_src = '1;
  logic [3*NM-1:0] m_period = '0;
  logic [2*NM-1:0] m_policy = '0;
  logic [2*NS-1:0] s_src = '1;
  logic [3*NS-1:0] s_up = '0, s_dn = '0;
  logic [NS-1:0]   s_sw_on = '0, pg_mon = '0, pg_in = '1;
  logic [NS-1:0]   s_en, s_lp;
  logic [NM-1:0]   m_busy, m_done;
  logic            pg_ok;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_top #(.N_MASTER(NM), .N_SLAVE(NS), .BASE_TICKS(BT)) uut (.*);

  typedef struct packed {
    logic [1:0] m;
    logic [1:0] src;
    logic [2:0] code;
    logic [2:0] rail;
    logic [2:0] up;
    logic [2:0] dn;
    logic [1:0] pol;
  } vec_t;

  // master, source, period code, rail, up slot, down slot, policy
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd7, 2'd1},
    '{2'd1, 2'd1, 3'd1, 3'd3, 3'd3, 3'd2, 2'd1},
    '{2'd2, 2'd2, 3'd2, 3'd5, 3'd7, 3'd0, 2'd2},
    '{2'd0, 2'd1, 3'd3, 3'd7, 3'd5, 3'd5, 2'd1},
    '{2'd1, 2'd2, 3'd4, 3'd1, 3'd1, 3'd6, 2'd0},
    '{2'd2, 2'd0, 3'd5, 3'd2, 3'd2, 3'd3, 2'd1},
    '{2'd0, 2'd2, 3'd6, 3'd4, 3'd6, 3'd1, 2'd2},
    '{2'd1, 2'd0, 3'd7, 3'd6, 3'd4, 3'd4, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_cfg();
    hw_en0 = 1'b0; hw_en1 = 1'b0; sw_trig = '0;
    m_src = '1; m_period = '0; m_policy = '0;
    s_src = '1; s_sw_on = '0; s_up = '0; s_dn = '0;
  endtask

  task automatic drive_trig(input logic [1:0] src, input int m, input logic val);
    case (src)
      2'd0: hw_en0 = val;
      2'd1: hw_en1 = val;
      default: sw_trig[m] = val;
    endcase
  endtask

  task automatic run_vec(input vec_t v);
    int p, t_up, t_dn, r, m;
    logic exp_en, exp_lp;
    p = BT << v.code;
    r = int'(v.rail);
    m = int'(v.m);
    clear_cfg();
    repeat (3) step();
    m_src[m*2 +: 2] = v.src;
    m_period[m*3 +: 3] = v.code;
    m_policy[m*2 +: 2] = v.pol;
    s_src[r*2 +: 2] = v.m;
    s_up[r*3 +: 3] = v.up;
    s_dn[r*3 +: 3] = v.dn;
    repeat (2) step();
    // rising sequence: R1 source selection, R2 timing, R3 power-up slot
    t_up = (int'(v.up) + 1) * p + 2;
    drive_trig(v.src, m, 1'b1);
    for (int c = 1; c <= 8 * p + 3; c++) begin
      step();
      if (c == t_up - 1) chk("R3 before up slot", s_en[r], 1'b0);
      if (c == t_up) begin
        chk("R3 at up slot en", s_en[r], 1'b1);
        chk("R3 at up slot lp", s_lp[r], 1'b0);
      end
      if (c == 8 * p + 1) chk("R2 done pulse", m_done[m], 1'b1);
    end
    chk("R2 idle after sequence", m_busy[m], 1'b0);
    // falling sequence: R4 sleep, R5 low power, R6 keep
    t_dn = (int'(v.dn) + 1) * p + 2;
    case (v.pol)
      2'd1:    begin exp_en = 1'b0; exp_lp = 1'b0; end
      2'd2:    begin exp_en = 1'b1; exp_lp = 1'b1; end
      default: begin exp_en = 1'b1; exp_lp = 1'b0; end
    endcase
    drive_trig(v.src, m, 1'b0);
    for (int c = 1; c <= 8 * p + 3; c++) begin
      step();
      if (c == t_dn - 1) begin
        chk("R4 before down slot en", s_en[r], 1'b1);
        chk("R5 before down slot lp", s_lp[r], 1'b0);
      end
      if (c == t_dn) begin
        chk((v.pol == 2'd1) ? "R4 sleep en" : (v.pol == 2'd2) ? "R5 lowpwr en" : "R6 keep en",
            s_en[r], exp_en);
        chk((v.pol == 2'd2) ? "R5 lowpwr lp" : "R6 lp", s_lp[r], exp_lp);
      end
    end
    chk("R6 state held after sequence", {s_en[r], s_lp[r]}, {exp_en, exp_lp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dones;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 s_en", s_en, '0);
    chk("R10 s_lp", s_lp, '0);
    chk("R10 m_busy", m_busy, '0);
    chk("R10 m_done", m_done, '0);
    chk("R9 no monitors", pg_ok, 1'b1);

    // R7 software rails
    s_sw_on = 8'hA5;
    chk("R7 no change before edge", s_en, 8'h00);
    step();
    chk("R7 follows sw bit", s_en, 8'hA5);
    chk("R7 lp low", s_lp, 8'h00);
    s_sw_on = 8'h3C;
    step();
    chk("R7 follows new sw bit", s_en, 8'h3C);

    // R9 combined power good
    pg_mon = 8'b0000_0110;
    #1 chk("R9 all good", pg_ok, 1'b1);
    pg_in[2] = 1'b0;
    #1 chk("R9 monitored drop", pg_ok, 1'b0);
    pg_in[2] = 1'b1; pg_in[3] = 1'b0;
    #1 chk("R9 unmonitored drop ignored", pg_ok, 1'b1);
    pg_in = '1; pg_mon = '0;

    // table of vectors
    foreach (VECS[i]) run_vec(VECS[i]);

    // R1 unselected pins start nothing
    clear_cfg();
    repeat (3) step();
    m_src = {2'd3, 2'd3, 2'd1};
    s_src[0 +: 2] = 2'd0; s_up[0 +: 3] = 3'd0;
    repeat (2) step();
    hw_en0 = 1'b1; sw_trig = '1;
    repeat (30) step();
    chk("R1 unselected busy", m_busy, 3'b000);
    chk("R1 unselected rail", s_en[0], 1'b0);
    hw_en0 = 1'b0; sw_trig = '0;
    repeat (2) step();

    // R8 abort and restart
    clear_cfg();
    repeat (3) step();
    m_src[0 +: 2] = 2'd0; m_period[0 +: 3] = 3'd0; m_policy[0 +: 2] = 2'd1;
    s_src[0 +: 2] = 2'd0; s_up[0 +: 3] = 3'd0; s_dn[0 +: 3] = 3'd2;
    s_src[2 +: 2] = 2'd0; s_up[3 +: 3] = 3'd5; s_dn[3 +: 3] = 3'd0;
    repeat (2) step();
    hw_en0 = 1'b1;
    repeat (5) step();
    chk("R8 slot0 reached", s_en[0], 1'b1);
    hw_en0 = 1'b0;
    dones = 0;
    for (int c = 1; c <= 8 * BT + 4; c++) begin
      step();
      if (m_done[0]) dones++;
      if (c == 1) chk("R8 busy kept through restart", m_busy[0], 1'b1);
      if (c == 3 * BT + 1) chk("R8 before restarted down slot", s_en[0], 1'b1);
      if (c == 3 * BT + 2) chk("R8 restarted down slot", s_en[0], 1'b0);
      if (s_en[1]) chk("R8 aborted up slot fired", s_en[1], 1'b0);
    end
    chk("R8 single done", dones, 1);
    chk("R8 rail1 never on", s_en[1], 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule